// File: doc/BRIEF.md
# Two-Wire Register Slave for a Digital Wiper

This block is the serial front end of a 7-bit digitally controlled wiper. It watches a two-wire bus (SCL and SDA) with the system clock and filters both lines. It picks out bus conditions and answers a slave address. That address is built from a fixed 5-bit type code, two strap inputs and a direction bit. The block acknowledges by pulling SDA low through an open-drain enable. It leaves the resistor decoding and the real nonvolatile storage to neighbouring logic. What it provides is a write strobe with data, a target select, a read data input and a busy input.

Registers are reached in two steps. A write to the access register (address 02h) chooses the target: 80h selects the volatile wiper register and 00h selects the nonvolatile data register. Writes to address 00h and reads then go to the chosen target. A read is a write of the address byte, then a repeated START, then the slave address with the read bit set. While `busy_i` is high, for example during a nonvolatile store, the block stays off the bus. A host can then poll the address until the block answers again.

States of `wpi_ctrl`:
- IDLE: the bus is free.
- DEV: the address byte is being shifted in.
- DEV_ACK: the block answers its address.
- REG: the register address byte is being shifted in.
- REG_ACK: the block answers the register address.
- DAT: a data byte is being shifted in.
- DAT_ACK: the block answers the data byte.
- TX: a byte is being sent.
- TX_ACK: the block samples the master's answer.
- IGNORE: the block waits for the next bus condition.

Transitions of `wpi_ctrl`:
- Any state goes to IDLE on STOP or while busy.
- Any state goes to DEV on START.
- DEV goes to DEV_ACK on an address match, or to IGNORE on a mismatch.
- DEV_ACK goes to TX for a read, or to REG for a write.
- REG goes to REG_ACK, and REG_ACK goes to DAT.
- DAT goes to DAT_ACK, and DAT_ACK goes back to DAT.
- TX goes to TX_ACK after eight bits.
- TX_ACK goes to TX if the master acknowledged, or to IGNORE if it did not.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the block leaves SDA released (`sda_oe`=0), `wr_stb` is low, and the target select is the wiper register (`tgt_sel`=1).
- R2: The block acknowledges an address byte only when bits 7..3 equal 01010 and bits 2..1 equal `strap_i[1:0]`. Bit 0 is the direction, with 1 meaning read. On any other address it gives no acknowledge and ignores the rest of the transfer up to the next START or STOP.
- R3: A write transfer is the address with bit 0 = 0, then register byte 00h, then a data byte. Each of the three bytes is acknowledged. The data byte produces exactly one single-cycle `wr_stb` pulse, with `wr_data` equal to bits 6..0 of the byte (bit 7 dropped) and `wr_tgt` equal to the current selection.
- R4: A data byte written to register 02h updates the selection. A value of 80h sets `tgt_sel`=1 (wiper) and 00h sets `tgt_sel`=0 (data register). Any other value leaves the selection unchanged, and no `wr_stb` is produced.
- R5: A read is the address with bit 0 = 1 after a repeated START. The block returns a byte whose bit 7 is 0 and whose bits 6..0 are `rd_data`, sent MSB first.
- R6: When the master acknowledges a byte sent by the block, the block sends the byte again. When the master does not acknowledge, the block keeps SDA released until the next START or STOP.
- R7: While `busy_i` is high, the block never drives SDA, does not acknowledge its own address and produces no `wr_stb`. After `busy_i` falls, its address is acknowledged again.
- R8: A STOP in the middle of a byte aborts the transfer without any write. A START in the middle of a byte begins a new address phase, and the new transfer completes normally.
- R9: The acknowledge is driven from the SCL falling edge after the eighth bit and released at the SCL falling edge after the ninth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_i | input | 2 | Address strap pins |
| busy_i | input | 1 | Nonvolatile store in progress; block stays off the bus |
| rd_data | input | 7 | Contents of the currently selected target |
| tgt_sel | output | 1 | Current target: 1 wiper, 0 data register |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_tgt | output | 1 | Target of the write that is strobed |
| wr_data | output | 7 | Data of the write that is strobed |

## Verification
The address decoder is swept over all four strap settings against all four address values. This tells a correct compare of both strap bits apart from a compare that ignores one of them or swaps them. A wrong type code is also sent, to show that the fixed bits are checked. Writes are sent with a spread of byte values, with bit 7 both set and clear, to both targets, and each is read back. This separates a dropped MSB from a stored one and a correct route from a swapped one. Further transfers cover aborts in mid-byte, a master NACK versus ACK during reads, and address polling while busy, which show that the protocol sequencing holds apart from the data path.

// File: rtl/wpi_pkg.sv
package wpi_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_DAT,
        ST_DAT_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } ctrl_state_t;

endpackage

// File: rtl/wpi_line_filter.sv
module wpi_line_filter #(
    parameter int SYNC_LEN = 2,
    parameter int VOTE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int HALF = VOTE_LEN / 2;

    logic [SYNC_LEN-1:0] sync_q;
    logic [VOTE_LEN-1:0] vote_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            vote_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], din};
            vote_q <= {vote_q[VOTE_LEN-2:0], sync_q[SYNC_LEN-1]};
            dout   <= ($countones(vote_q) > HALF);
        end
    end
endmodule

// File: rtl/wpi_bus_events.sv
module wpi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    always_comb begin
        start_ev = scl_f & scl_d & sda_d & ~sda_f;
        stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
        scl_rise = scl_f & ~scl_d;
        scl_fall = ~scl_f & scl_d;
    end
endmodule

// File: rtl/wpi_ctrl.sv
module wpi_ctrl
    import wpi_pkg::*;
#(
    parameter int          DW         = 7,
    parameter logic [4:0]  DEV_ID     = 5'b01010,
    parameter logic [7:0]  REG_DATA   = 8'h00,
    parameter logic [7:0]  REG_ACCESS = 8'h02,
    parameter logic [7:0]  SEL_WIPER  = 8'h80,
    parameter logic [7:0]  SEL_STORE  = 8'h00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_f,
    input  logic [1:0]    strap_i,
    input  logic          busy_i,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic          tgt_sel,
    output logic          wr_stb,
    output logic          wr_tgt,
    output logic [DW-1:0] wr_data
);
    localparam int PAD = 8 - DW;

    ctrl_state_t state;
    byte_t       rx_sh;
    byte_t       tx_sh;
    byte_t       reg_ptr;
    logic [2:0]  bit_cnt;
    logic        got8;
    logic        rw_q;
    logic        mack_q;
    logic        addr_hit;

    assign addr_hit = (rx_sh[7:3] == DEV_ID) && (rx_sh[2:1] == strap_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rx_sh   <= '0;
            tx_sh   <= '0;
            reg_ptr <= '0;
            bit_cnt <= '0;
            got8    <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            tgt_sel <= 1'b1;
            wr_stb  <= 1'b0;
            wr_tgt  <= 1'b1;
            wr_data <= '0;
        end else if (busy_i) begin
            state  <= ST_IDLE;
            wr_stb <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (stop_ev) begin
                state <= ST_IDLE;
            end else if (start_ev) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
                got8    <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: ;
                    ST_DEV, ST_REG, ST_DAT: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_f};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) got8 <= 1'b1;
                        end else if (scl_fall && got8) begin
                            got8 <= 1'b0;
                            if (state == ST_DEV) begin
                                rw_q  <= rx_sh[0];
                                state <= addr_hit ? ST_DEV_ACK : ST_IGNORE;
                            end else if (state == ST_REG) begin
                                reg_ptr <= rx_sh;
                                state   <= ST_REG_ACK;
                            end else begin
                                if (reg_ptr == REG_ACCESS) begin
                                    if (rx_sh == SEL_WIPER)      tgt_sel <= 1'b1;
                                    else if (rx_sh == SEL_STORE) tgt_sel <= 1'b0;
                                end else if (reg_ptr == REG_DATA) begin
                                    wr_stb  <= 1'b1;
                                    wr_tgt  <= tgt_sel;
                                    wr_data <= rx_sh[DW-1:0];
                                end
                                state <= ST_DAT_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                state <= ST_TX;
                                tx_sh <= {{PAD{1'b0}}, rd_data};
                            end else begin
                                state <= ST_REG;
                            end
                        end
                    end
                    ST_REG_ACK, ST_DAT_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            state   <= ST_DAT;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                state <= ST_TX_ACK;
                            end else begin
                                tx_sh   <= {tx_sh[6:0], 1'b0};
                                bit_cnt <= bit_cnt + 3'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_f;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (mack_q) begin
                                state <= ST_TX;
                                tx_sh <= {{PAD{1'b0}}, rd_data};
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        if (!busy_i) begin
            unique case (state)
                ST_DEV_ACK, ST_REG_ACK, ST_DAT_ACK: sda_oe = 1'b1;
                ST_TX:                              sda_oe = ~tx_sh[7];
                ST_IDLE, ST_DEV, ST_REG, ST_DAT,
                ST_TX_ACK, ST_IGNORE:               sda_oe = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
    parameter int         DW       = 7,
    parameter logic [4:0] DEV_ID   = 5'b01010,
    parameter int         SYNC_LEN = 2,
    parameter int         VOTE_LEN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [1:0]    strap_i,
    input  logic          busy_i,
    input  logic [DW-1:0] rd_data,
    output logic          tgt_sel,
    output logic          wr_stb,
    output logic          wr_tgt,
    output logic [DW-1:0] wr_data
);
    logic [1:0] line_raw, line_flt;
    logic start_ev, stop_ev, scl_rise, scl_fall;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        wpi_line_filter #(.SYNC_LEN(SYNC_LEN), .VOTE_LEN(VOTE_LEN)) u_flt (
            .clk(clk), .rst_n(rst_n), .din(line_raw[g]), .dout(line_flt[g])
        );
    end

    wpi_bus_events u_ev (
        .clk(clk), .rst_n(rst_n),
        .scl_f(line_flt[0]), .sda_f(line_flt[1]),
        .start_ev(start_ev), .stop_ev(stop_ev),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    wpi_ctrl #(.DW(DW), .DEV_ID(DEV_ID)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_ev(start_ev), .stop_ev(stop_ev),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_f(line_flt[1]), .strap_i(strap_i), .busy_i(busy_i),
        .rd_data(rd_data), .sda_oe(sda_oe), .tgt_sel(tgt_sel),
        .wr_stb(wr_stb), .wr_tgt(wr_tgt), .wr_data(wr_data)
    );
endmodule

// File: rtl/wpi_checks.sv
module wpi_checks (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic sda_oe,
    input logic wr_stb,
    input logic tgt_sel,
    input logic scl_fall
);
    // R9: the acknowledge or a low data bit starts only after an SCL fall
    assert_drive_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R3: a strobe lasts exactly one cycle
    assert_stb_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R3: a strobe follows the fall that ends the eighth data bit
    assert_stb_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(scl_fall));

    // R4: the selection only moves after an SCL fall
    assert_sel_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tgt_sel) |-> $past(scl_fall));

    // R7: no strobe in the cycle after busy was seen
    assert_busy_no_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !wr_stb);
endmodule

bind wiper_i2c_slave wpi_checks u_chk (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .tgt_sel(tgt_sel), .scl_fall(scl_fall)
);

// File: tb/wiper_i2c_slave_tb.sv
module wiper_i2c_slave_tb;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [1:0] strap = 2'd0;
    logic       busy = 1'b0;
    logic [6:0] wmod = 7'h40;
    logic [6:0] smod = 7'h11;
    logic       sda_oe, tgt_sel, wr_stb, wr_tgt;
    logic [6:0] wr_data, rd_data;
    logic       sda_bus;

    int checks = 0, errors = 0, stb_cnt = 0, busy_viol = 0;
    logic [6:0] last_data;
    logic       last_tgt;
    logic       finished = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = ~(m_low | sda_oe);
    assign rd_data = tgt_sel ? wmod : smod;

    wiper_i2c_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_i(strap), .busy_i(busy), .rd_data(rd_data), .tgt_sel(tgt_sel),
        .wr_stb(wr_stb), .wr_tgt(wr_tgt), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            last_data = wr_data;
            last_tgt  = wr_tgt;
            if (wr_tgt) wmod = wr_data;
            else begin smod = wr_data; wmod = wr_data; end
        end
        if (busy && sda_oe) busy_viol++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic slot(input logic b, output logic smp);
        m_low = ~b; qw();
        scl = 1'b1; qw();
        smp = sda_bus; qw();
        scl = 1'b0; qw();
    endtask

    task automatic bus_start();
        m_low = 1'b0; qw();
        scl = 1'b1; qw();
        m_low = 1'b1; qw();
        scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qw();
        scl = 1'b1; qw();
        m_low = 1'b0; qw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) slot(b[i], s);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        send_bits(b, 8);
        slot(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            slot(1'b1, s);
            v[i] = s;
        end
        slot(~mack, s);
    endtask

    task automatic reg_write(input logic [7:0] ra, input logic [7:0] d, output int acks);
        logic a;
        acks = 0;
        bus_start();
        send_byte({5'b01010, strap, 1'b0}, a); acks += a;
        send_byte(ra, a); acks += a;
        send_byte(d, a); acks += a;
        bus_stop();
    endtask

    task automatic reg_read(output logic [7:0] v);
        logic a;
        bus_start();
        send_byte({5'b01010, strap, 1'b0}, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte({5'b01010, strap, 1'b1}, a);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] v;
        int acks, s0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 sda", int'(sda_oe), 0);
        chk("R1 stb", int'(wr_stb), 0);
        chk("R1 sel", int'(tgt_sel), 1);

        // R2 strap sweep
        for (int st = 0; st < 4; st++) begin
            for (int ad = 0; ad < 4; ad++) begin
                strap = st[1:0];
                bus_start();
                send_byte({5'b01010, ad[1:0], 1'b0}, a);
                bus_stop();
                chk("R2 addr match", int'(a), int'(st == ad));
            end
        end
        strap = 2'd2;
        // R2 wrong type code, rest ignored
        s0 = stb_cnt;
        bus_start();
        send_byte({5'b01011, strap, 1'b0}, a);
        chk("R2 bad id", int'(a), 0);
        send_byte(8'h00, a);
        chk("R2 ignored byte", int'(a), 0);
        send_byte(8'h5A, a);
        bus_stop();
        chk("R2 no write", stb_cnt - s0, 0);

        // R3 write sweep to wiper, R9 release after ack
        for (int i = 0; i < 12; i++) begin
            v = 8'((i * 83 + 5) & 255);
            s0 = stb_cnt;
            reg_write(8'h00, v, acks);
            chk("R3 acks", acks, 3);
            chk("R3 one strobe", stb_cnt - s0, 1);
            chk("R3 data", int'(last_data), int'(v[6:0]));
            chk("R3 target", int'(last_tgt), 1);
            chk("R9 released after ninth", int'(sda_oe), 0);
        end

        // R4 select data register
        reg_write(8'h02, 8'h00, acks);
        chk("R4 sel store", int'(tgt_sel), 0);
        s0 = stb_cnt;
        reg_write(8'h00, 8'hD3, acks);
        chk("R3 store target", int'(last_tgt), 0);
        chk("R3 store data", int'(last_data), 7'h53);
        reg_write(8'h02, 8'h55, acks);
        chk("R4 other value ignored", int'(tgt_sel), 0);
        chk("R4 no strobe", stb_cnt - s0, 1);
        reg_read(v);
        chk("R5 read store", int'(v), 8'h53);
        smod = 7'h2C;
        reg_read(v);
        chk("R5 read store msb0", int'(v), 8'h2C);
        reg_write(8'h02, 8'h80, acks);
        chk("R4 sel wiper", int'(tgt_sel), 1);

        // R5 read sweep on wiper
        for (int i = 0; i < 5; i++) begin
            v = 8'((i * 61 + 200) & 255);
            reg_write(8'h00, v, acks);
            reg_read(v);
            chk("R5 read wiper", int'(v), int'({1'b0, wmod}));
        end

        // R6 master ACK repeats, NACK releases
        wmod = 7'h35;
        bus_start();
        send_byte({5'b01010, strap, 1'b0}, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte({5'b01010, strap, 1'b1}, a);
        recv_byte(1'b1, v);
        chk("R6 first", int'(v), 8'h35);
        recv_byte(1'b0, v);
        chk("R6 repeat", int'(v), 8'h35);
        recv_byte(1'b0, v);
        chk("R6 released after nack", int'(v), 8'hFF);
        bus_stop();

        // R7 busy
        busy = 1'b1;
        s0 = stb_cnt;
        reg_write(8'h00, 8'h12, acks);
        chk("R7 no ack while busy", acks, 0);
        chk("R7 no strobe", stb_cnt - s0, 0);
        chk("R7 sda never driven", busy_viol, 0);
        busy = 1'b0;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte({5'b01010, strap, 1'b0}, a);
        bus_stop();
        chk("R7 poll ack", int'(a), 1);

        // R8 stop mid-byte
        s0 = stb_cnt;
        bus_start();
        send_byte({5'b01010, strap, 1'b0}, a);
        send_byte(8'h00, a);
        send_bits(8'h7E, 4);
        scl = 1'b0; bus_stop();
        chk("R8 stop abort", stb_cnt - s0, 0);
        // R8 start mid-byte
        bus_start();
        send_byte({5'b01010, strap, 1'b0}, a);
        send_bits(8'hFF, 3);
        bus_start();
        send_byte({5'b01010, strap, 1'b0}, a);
        chk("R8 restart ack", int'(a), 1);
        send_byte(8'h00, a);
        send_byte(8'h66, a);
        bus_stop();
        chk("R8 restart write", stb_cnt - s0, 1);
        chk("R8 restart data", int'(last_data), 7'h66);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule